// File: doc/BRIEF.md
# Half-Duplex Line Direction Controller

This block sits beside a UART transmitter and drives the enable pin of an RS485 line driver. When the automatic mode is on, it changes the pin level on its own around each burst of characters. A write into the transmit holding register or FIFO raises the pin before the shifter can start that character. The pin drops only on the baud tick that ends the stop bit of the last queued character. Between back-to-back characters the pin stays high.

The same mode bit also chooses what raises the transmit interrupt. With the mode off, the interrupt fires as soon as the holding register and FIFO are empty, even while the shifter is still sending. In that case the pin simply follows the software-set RTS value. With the mode on, the interrupt waits until the shifter is idle as well.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: While `rst_n` is low, `dir_pin` is 1 and `tx_irq` is 0.
- R2: With `auto_en` = 0, `dir_pin` takes the value of `sw_rts` one clock after that value is sampled.
- R3: With `auto_en` = 0, `tx_irq` one clock later equals `fifo_empty`, and `tsr_busy` has no effect on it.
- R4: With `auto_en` = 1, a cycle with `thr_wr` = 1 makes `dir_pin` 1 in the next clock. This is before any start bit, which the shifter begins no earlier than a later baud tick.
- R5: With `auto_en` = 1, a cycle with `baud_tick`, `stop_last` and `fifo_empty` all 1 and `thr_wr` = 0 makes `dir_pin` 0 in the next clock. After that the pin holds 0 until a write.
- R6: With `auto_en` = 1, if the stop bit ends while `fifo_empty` = 0 (a byte is still queued), `dir_pin` stays 1.
- R7: With `auto_en` = 1, `stop_last` without `baud_tick` does not change `dir_pin`, so the pin never moves in the middle of a bit.
- R8: With `auto_en` = 1, `tx_irq` one clock later equals `fifo_empty` AND NOT `tsr_busy`. In other words, it signals that the shift register is empty.
- R9: With `auto_en` = 1, a write in the same cycle as the end of the final stop bit keeps `dir_pin` at 1. The write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | 1 = automatic direction mode, 0 = standard mode |
| sw_rts | input | 1 | Software-programmed RTS level, used in standard mode |
| thr_wr | input | 1 | One-cycle strobe: a byte was written to the holding register or FIFO |
| fifo_empty | input | 1 | Holding register and FIFO both empty |
| tsr_busy | input | 1 | Shift register is still sending a character |
| stop_last | input | 1 | Shifter is in the final baud period of a stop bit |
| baud_tick | input | 1 | One-cycle baud period boundary |
| dir_pin | output | 1 | Driver direction pin |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The bench builds the block with its default parameters: no pin inversion and a registered interrupt. With these defaults every output lands exactly one clock after the inputs that cause it. That one-clock timing brings within reach the orderings that matter most:
- a write that coincides with the end of the final stop bit;
- a stop-bit end while a byte is still queued;
- `stop_last` held across cycles without a baud tick.

A change of mode between bursts is also covered. The interrupt source is checked with the shifter busy and idle under both settings of the mode bit.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

   typedef enum logic {
      LVL_LO = 1'b0,
      LVL_HI = 1'b1
   } line_lvl_e;

endpackage

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
   import rs485_dir_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      auto_en,
   input  logic      sw_rts,
   input  logic      thr_wr,
   input  logic      fifo_empty,
   input  logic      stop_last,
   input  logic      baud_tick,
   output line_lvl_e level
);

   line_lvl_e level_nxt;
   logic      burst_done;

   // the last character is gone only when its stop bit closes on a tick
   // and nothing is waiting behind it
   assign burst_done = baud_tick & stop_last & fifo_empty;

   always_comb begin
      level_nxt = level;
      if (!auto_en) begin
         level_nxt = sw_rts ? LVL_HI : LVL_LO;
      end else if (thr_wr) begin
         level_nxt = LVL_HI;
      end else if (burst_done) begin
         level_nxt = LVL_LO;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level <= LVL_HI;
      else        level <= level_nxt;
   end

endmodule

// File: rtl/rs485_irq_sel.sv
module rs485_irq_sel #(
   parameter int IRQ_REG = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_en,
   input  logic fifo_empty,
   input  logic tsr_busy,
   output logic tx_irq
);

   logic irq_src;

   // standard mode: holding side empty; auto mode: shifter drained too
   assign irq_src = auto_en ? (fifo_empty & ~tsr_busy) : fifo_empty;

   generate
      if (IRQ_REG != 0) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_src;
         end
         assign tx_irq = irq_q;
      end else begin : g_comb
         assign tx_irq = rst_n & irq_src;
      end
   endgenerate

endmodule

// File: rtl/rs485_pin_drv.sv
module rs485_pin_drv
   import rs485_dir_pkg::*;
#(
   parameter int PIN_INVERT = 0
) (
   input  line_lvl_e level,
   output logic      dir_pin
);

   generate
      if (PIN_INVERT != 0) begin : g_inv
         assign dir_pin = ~level;
      end else begin : g_pass
         assign dir_pin = level;
      end
   endgenerate

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
   import rs485_dir_pkg::*;
#(
   parameter int PIN_INVERT = 0,
   parameter int IRQ_REG    = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_en,
   input  logic sw_rts,
   input  logic thr_wr,
   input  logic fifo_empty,
   input  logic tsr_busy,
   input  logic stop_last,
   input  logic baud_tick,
   output logic dir_pin,
   output logic tx_irq
);

   initial begin
      assert (PIN_INVERT == 0 || PIN_INVERT == 1)
         else $error("PIN_INVERT must be 0 or 1");
      assert (IRQ_REG == 0 || IRQ_REG == 1)
         else $error("IRQ_REG must be 0 or 1");
   end

   line_lvl_e level;

   rs485_dir_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .auto_en    (auto_en),
      .sw_rts     (sw_rts),
      .thr_wr     (thr_wr),
      .fifo_empty (fifo_empty),
      .stop_last  (stop_last),
      .baud_tick  (baud_tick),
      .level      (level)
   );

   rs485_irq_sel #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .auto_en    (auto_en),
      .fifo_empty (fifo_empty),
      .tsr_busy   (tsr_busy),
      .tx_irq     (tx_irq)
   );

   rs485_pin_drv #(.PIN_INVERT(PIN_INVERT)) u_pin (
      .level   (level),
      .dir_pin (dir_pin)
   );

endmodule

// File: rtl/rs485_dir_chk.sv
module rs485_dir_chk #(
   parameter int PIN_INVERT = 0,
   parameter int IRQ_REG    = 1
) (
   input logic clk,
   input logic rst_n,
   input logic auto_en,
   input logic sw_rts,
   input logic thr_wr,
   input logic fifo_empty,
   input logic tsr_busy,
   input logic stop_last,
   input logic baud_tick,
   input logic dir_pin,
   input logic tx_irq
);

   localparam bit INV = (PIN_INVERT != 0);

   logic lvl;
   assign lvl = dir_pin ^ INV;

   // R2: standard mode mirrors the software level
   assert_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_en |=> (lvl == $past(sw_rts)));

   // R4: a write raises the pin before the start bit
   assert_rise_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && thr_wr) |=> lvl);

   // R5: release after the final stop bit
   assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && !thr_wr && baud_tick && stop_last && fifo_empty) |=> !lvl);

   // R6 / R7: no fall without a tick-aligned end of the last stop bit
   assert_hold_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && lvl && !(baud_tick && stop_last && fifo_empty)) |=> lvl);

   // R5: once released, the pin stays low until a write
   assert_hold_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && !lvl && !thr_wr) |=> !lvl);

   generate
      if (IRQ_REG != 0) begin : g_irq_reg
         // R8
         assert_irq_tsr_R8: assert property (@(posedge clk) disable iff (!rst_n)
            auto_en |=> (tx_irq == $past(fifo_empty && !tsr_busy)));
         // R3
         assert_irq_thr_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !auto_en |=> (tx_irq == $past(fifo_empty)));
      end else begin : g_irq_comb
         // R8
         assert_irq_tsr_R8: assert property (@(posedge clk) disable iff (!rst_n)
            auto_en |-> (tx_irq == (fifo_empty && !tsr_busy)));
         // R3
         assert_irq_thr_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !auto_en |-> (tx_irq == fifo_empty));
      end
   endgenerate

endmodule

bind rs485_dir_ctrl rs485_dir_chk #(
   .PIN_INVERT (PIN_INVERT),
   .IRQ_REG    (IRQ_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .auto_en    (auto_en),
   .sw_rts     (sw_rts),
   .thr_wr     (thr_wr),
   .fifo_empty (fifo_empty),
   .tsr_busy   (tsr_busy),
   .stop_last  (stop_last),
   .baud_tick  (baud_tick),
   .dir_pin    (dir_pin),
   .tx_irq     (tx_irq)
);

// File: tb/rs485_dir_ctrl_tb.sv
module rs485_dir_ctrl_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic auto_en = 1'b0;
   logic sw_rts = 1'b1;
   logic thr_wr = 1'b0;
   logic fifo_empty = 1'b1;
   logic tsr_busy = 1'b0;
   logic stop_last = 1'b0;
   logic baud_tick = 1'b0;
   logic dir_pin;
   logic tx_irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rs485_dir_ctrl u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .auto_en    (auto_en),
      .sw_rts     (sw_rts),
      .thr_wr     (thr_wr),
      .fifo_empty (fifo_empty),
      .tsr_busy   (tsr_busy),
      .stop_last  (stop_last),
      .baud_tick  (baud_tick),
      .dir_pin    (dir_pin),
      .tx_irq     (tx_irq)
   );

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      thr_wr = 1'b0; stop_last = 1'b0; baud_tick = 1'b0;
   endtask

   task automatic t_reset();
      tick();
      chk("R1 dir", dir_pin, 1'b1);
      chk("R1 irq", tx_irq, 1'b0);
      rst_n = 1'b1;
   endtask

   task automatic t_std_mirror();
      auto_en = 1'b0;
      sw_rts = 1'b0; tick();
      chk("R2 low", dir_pin, 1'b0);
      sw_rts = 1'b1; tick();
      chk("R2 high", dir_pin, 1'b1);
   endtask

   task automatic t_std_irq();
      auto_en = 1'b0;
      fifo_empty = 1'b1; tsr_busy = 1'b1; tick();
      chk("R3 empty busy", tx_irq, 1'b1);
      fifo_empty = 1'b0; tsr_busy = 1'b0; tick();
      chk("R3 queued", tx_irq, 1'b0);
   endtask

   task automatic t_release_and_write();
      auto_en = 1'b1; sw_rts = 1'b1; fifo_empty = 1'b1;
      stop_last = 1'b1; baud_tick = 1'b1; tick();
      chk("R5 release", dir_pin, 1'b0);
      idle_inputs();
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R5 stays low", dir_pin, 1'b0);
      end
      thr_wr = 1'b1; fifo_empty = 1'b0; tick();
      chk("R4 rise on write", dir_pin, 1'b1);
      thr_wr = 1'b0;
   endtask

   task automatic t_back_to_back();
      auto_en = 1'b1; fifo_empty = 1'b0;
      stop_last = 1'b1; baud_tick = 1'b1; tick();
      chk("R6 queued byte keeps high", dir_pin, 1'b1);
      idle_inputs();
   endtask

   task automatic t_no_midbit();
      auto_en = 1'b1; fifo_empty = 1'b1;
      stop_last = 1'b1; baud_tick = 1'b0;
      tick();
      chk("R7 no tick 1", dir_pin, 1'b1);
      tick();
      chk("R7 no tick 2", dir_pin, 1'b1);
      baud_tick = 1'b1; tick();
      chk("R5 tick releases", dir_pin, 1'b0);
      idle_inputs();
   endtask

   task automatic t_write_wins();
      auto_en = 1'b1; fifo_empty = 1'b1;
      thr_wr = 1'b1; stop_last = 1'b1; baud_tick = 1'b1; tick();
      chk("R9 write wins", dir_pin, 1'b1);
      idle_inputs(); fifo_empty = 1'b0;
   endtask

   task automatic t_auto_irq();
      auto_en = 1'b1;
      fifo_empty = 1'b1; tsr_busy = 1'b1; tick();
      chk("R8 shifter busy", tx_irq, 1'b0);
      tsr_busy = 1'b0; tick();
      chk("R8 shifter idle", tx_irq, 1'b1);
      fifo_empty = 1'b0; tick();
      chk("R8 queued", tx_irq, 1'b0);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_std_mirror();
      t_std_irq();
      t_release_and_write();
      t_back_to_back();
      t_no_midbit();
      t_write_wins();
      t_auto_irq();
      t_std_mirror();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule